// File: doc/BRIEF.md
# Pipelined Modular Add-and-Halve Unit

This unit returns S = (A + B) · 2⁻¹ mod N for an odd modulus N, with both operands already reduced below N. It serves as the addition step of a modular arithmetic datapath in which every sum has to be halved, such as the doubling and addition steps of a Lucas-sequence evaluation. No divider is needed. When A + B is odd, N is added so that the sum becomes even. The halved value is then corrected by at most one subtraction of N.

The datapath is cut into SEGS equal slices. Carries and borrows pass from one slice to the next through registers, so the critical path is one slice wide at any operand width. A new operation can enter on every clock. Each operation leaves exactly SEGS + 2 cycles later, carrying the tag it came in with.

Top module: `modhalf_unit`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge yields `out_valid` high exactly SEGS + 2 rising edges later. Operations presented on consecutive clocks come out on consecutive clocks and in the same order.
- R2: When A + B is even, `out_sum` equals (A + B) / 2.
- R3: When A + B is odd and (A + B + N) / 2 is below N, `out_sum` equals (A + B + N) / 2.
- R4: When A + B is odd and (A + B + N) / 2 is at least N, `out_sum` equals (A + B + N) / 2 − N.
- R5: Every result is strictly below the modulus it was computed with.
- R6: `out_tag` carries the tag that was presented with the same operation.
- R7: A synchronous reset drops every operation in flight. After reset, `out_valid` stays low until a newly accepted operation reaches the output. Idle input cycles produce no output.
- R8: The result is exact at the extremes of the modulus range: N = 1, and N = 2^WIDTH − 1 with operands near N, where carries run through every slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_tag | input | TAGW | Caller label returned with the result |
| in_a | input | WIDTH | First addend, below `in_mod` |
| in_b | input | WIDTH | Second addend, below `in_mod` |
| in_mod | input | WIDTH | Odd modulus |
| out_valid | output | 1 | Result present on the outputs |
| out_tag | output | TAGW | Label of the returned operation |
| out_sum | output | WIDTH | (A + B) · 2⁻¹ mod N |

## Verification
The assertions rely on two input conditions: every accepted modulus is odd, and both addends are strictly below it. Under those conditions one conditional subtraction is enough and the result can be predicted. The stimulus builds each odd modulus by forcing its least significant bit to one. Each modulus is also shifted right by a random amount, so that small and full-width moduli both occur. Both addends are then taken as remainders modulo that value, so no operation outside the legal range is ever presented.

// File: rtl/modhalf_pkg.sv
package modhalf_pkg;

    // Which formula produces the result.
    typedef enum logic [1:0] {
        PATH_HALF     = 2'd0,  // even sum: plain halving
        PATH_FOLD     = 2'd1,  // odd sum: (A+B+N)/2 already below N
        PATH_FOLD_SUB = 2'd2   // odd sum: (A+B+N)/2 - N
    } fold_path_e;

    // Number of register stages from input to output.
    function automatic int pipe_depth(input int segs);
        return segs + 2;
    endfunction

    // Width of one slice of the datapath.
    function automatic int seg_width(input int width, input int segs);
        return width / segs;
    endfunction

endpackage

// File: rtl/modhalf_pick.sv
module modhalf_pick
    import modhalf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   sum,
    input  logic [WIDTH+1:0] sumn,
    input  logic [WIDTH-1:0] diff,
    input  logic             borrow,
    output logic [WIDTH-1:0] res
);

    fold_path_e path;

    // The halved value reaches N when its top bit is set or when the
    // subtraction of N did not borrow.
    always_comb begin
        if (!sum[0])
            path = PATH_HALF;
        else if (sumn[WIDTH+1] || !borrow)
            path = PATH_FOLD_SUB;
        else
            path = PATH_FOLD;
    end

    always_comb begin
        unique case (path)
            PATH_HALF: res = sum[WIDTH:1];
            PATH_FOLD: res = sumn[WIDTH:1];
            default:   res = diff;
        endcase
    end

endmodule

// File: rtl/modhalf_stage.sv
module modhalf_stage
    import modhalf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEGS  = 4,
    parameter int TAGW  = 4,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             p_vld,
    input  logic [TAGW-1:0]  p_tag,
    input  logic [WIDTH-1:0] p_a,
    input  logic [WIDTH-1:0] p_b,
    input  logic [WIDTH-1:0] p_n,
    input  logic [WIDTH:0]   p_sum,
    input  logic [WIDTH+1:0] p_sumn,
    input  logic             p_c1,
    input  logic             p_c2,
    input  logic [WIDTH-1:0] p_diff,
    input  logic             p_bw,
    input  logic [WIDTH-1:0] p_res,
    output logic             q_vld,
    output logic [TAGW-1:0]  q_tag,
    output logic [WIDTH-1:0] q_a,
    output logic [WIDTH-1:0] q_b,
    output logic [WIDTH-1:0] q_n,
    output logic [WIDTH:0]   q_sum,
    output logic [WIDTH+1:0] q_sumn,
    output logic             q_c1,
    output logic             q_c2,
    output logic [WIDTH-1:0] q_diff,
    output logic             q_bw,
    output logic [WIDTH-1:0] q_res
);

    localparam int SW       = seg_width(WIDTH, SEGS);
    localparam bit ADD_ON   = (IDX < SEGS);
    localparam bit LAST_ADD = (IDX == SEGS - 1);
    localparam bit SUB_ON   = (IDX >= 2);
    localparam bit PICK_ON  = (IDX == SEGS + 1);
    localparam int LO_A     = ADD_ON ? IDX * SW : 0;
    localparam int LO_S     = SUB_ON ? (IDX - 2) * SW : 0;

    logic [SW:0]        add_s, add_t, sub_d;
    logic [WIDTH:0]     n_sum;
    logic [WIDTH+1:0]   n_sumn;
    logic               n_c1, n_c2, n_bw;
    logic [WIDTH-1:0]   n_diff, n_res, pick_res;

    // Both adder rows for this stage's slice, plus one slice of the
    // subtract row. The subtract row runs two slices behind, because the
    // shifted sum needs the low bit of the slice above it.
    always_comb begin
        add_s  = {1'b0, p_a[LO_A +: SW]} + {1'b0, p_b[LO_A +: SW]} + {{SW{1'b0}}, p_c1};
        add_t  = {1'b0, add_s[SW-1:0]} + {1'b0, p_n[LO_A +: SW]} + {{SW{1'b0}}, p_c2};
        sub_d  = {1'b0, p_sumn[LO_S + 1 +: SW]} - {1'b0, p_n[LO_S +: SW]} - {{SW{1'b0}}, p_bw};
        n_sum  = p_sum;
        n_sumn = p_sumn;
        n_c1   = p_c1;
        n_c2   = p_c2;
        n_diff = p_diff;
        n_bw   = p_bw;
        if (ADD_ON) begin
            n_sum[LO_A +: SW]  = add_s[SW-1:0];
            n_sumn[LO_A +: SW] = add_t[SW-1:0];
            n_c1 = add_s[SW];
            n_c2 = add_t[SW];
            if (LAST_ADD) begin
                n_sum[WIDTH]           = add_s[SW];
                n_sumn[WIDTH+1:WIDTH]  = {1'b0, add_s[SW]} + {1'b0, add_t[SW]};
            end
        end
        if (SUB_ON) begin
            n_diff[LO_S +: SW] = sub_d[SW-1:0];
            n_bw = sub_d[SW];
        end
    end

    modhalf_pick #(.WIDTH(WIDTH)) u_pick (
        .sum    (p_sum),
        .sumn   (p_sumn),
        .diff   (n_diff),
        .borrow (n_bw),
        .res    (pick_res)
    );

    assign n_res = PICK_ON ? pick_res : p_res;

    always_ff @(posedge clk) begin
        if (rst) q_vld <= 1'b0;
        else     q_vld <= p_vld;
        q_tag  <= p_tag;
        q_a    <= p_a;
        q_b    <= p_b;
        q_n    <= p_n;
        q_sum  <= n_sum;
        q_sumn <= n_sumn;
        q_c1   <= n_c1;
        q_c2   <= n_c2;
        q_diff <= n_diff;
        q_bw   <= n_bw;
        q_res  <= n_res;
    end

endmodule

// File: rtl/modhalf_unit.sv
module modhalf_unit
    import modhalf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEGS  = 4,
    parameter int TAGW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAGW-1:0]  in_tag,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_mod,
    output logic             out_valid,
    output logic [TAGW-1:0]  out_tag,
    output logic [WIDTH-1:0] out_sum
);

    localparam int DEPTH = pipe_depth(SEGS);

    logic             pvld  [0:DEPTH];
    logic [TAGW-1:0]  ptag  [0:DEPTH];
    logic [WIDTH-1:0] pa    [0:DEPTH];
    logic [WIDTH-1:0] pb    [0:DEPTH];
    logic [WIDTH-1:0] pn    [0:DEPTH];
    logic [WIDTH:0]   psum  [0:DEPTH];
    logic [WIDTH+1:0] psumn [0:DEPTH];
    logic             pc1   [0:DEPTH];
    logic             pc2   [0:DEPTH];
    logic [WIDTH-1:0] pdiff [0:DEPTH];
    logic             pbw   [0:DEPTH];
    logic [WIDTH-1:0] pres  [0:DEPTH];

    assign pvld[0]  = in_valid;
    assign ptag[0]  = in_tag;
    assign pa[0]    = in_a;
    assign pb[0]    = in_b;
    assign pn[0]    = in_mod;
    assign psum[0]  = '0;
    assign psumn[0] = '0;
    assign pc1[0]   = 1'b0;
    assign pc2[0]   = 1'b0;
    assign pdiff[0] = '0;
    assign pbw[0]   = 1'b0;
    assign pres[0]  = '0;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        modhalf_stage #(
            .WIDTH (WIDTH),
            .SEGS  (SEGS),
            .TAGW  (TAGW),
            .IDX   (k)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .p_vld  (pvld[k]),  .p_tag  (ptag[k]),
            .p_a    (pa[k]),    .p_b    (pb[k]),    .p_n    (pn[k]),
            .p_sum  (psum[k]),  .p_sumn (psumn[k]),
            .p_c1   (pc1[k]),   .p_c2   (pc2[k]),
            .p_diff (pdiff[k]), .p_bw   (pbw[k]),   .p_res  (pres[k]),
            .q_vld  (pvld[k+1]),  .q_tag  (ptag[k+1]),
            .q_a    (pa[k+1]),    .q_b    (pb[k+1]),    .q_n    (pn[k+1]),
            .q_sum  (psum[k+1]),  .q_sumn (psumn[k+1]),
            .q_c1   (pc1[k+1]),   .q_c2   (pc2[k+1]),
            .q_diff (pdiff[k+1]), .q_bw   (pbw[k+1]),   .q_res  (pres[k+1])
        );
    end

    assign out_valid = pvld[DEPTH];
    assign out_tag   = ptag[DEPTH];
    assign out_sum   = pres[DEPTH];

endmodule

// File: rtl/modhalf_chk.sv
module modhalf_chk
    import modhalf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEGS  = 4,
    parameter int TAGW  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [TAGW-1:0]  in_tag,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic [WIDTH-1:0] in_mod,
    input logic             out_valid,
    input logic [TAGW-1:0]  out_tag,
    input logic [WIDTH-1:0] out_sum
);

    localparam int DEPTH = pipe_depth(SEGS);

    logic             d_vld [0:DEPTH-1];
    logic [TAGW-1:0]  d_tag [0:DEPTH-1];
    logic [WIDTH-1:0] d_exp [0:DEPTH-1];
    logic [WIDTH-1:0] d_mod [0:DEPTH-1];
    logic [WIDTH+1:0] tot, half;
    logic [WIDTH-1:0] exp_now;

    // Reference result, computed at the input.
    always_comb begin
        tot = {2'b00, in_a} + {2'b00, in_b};
        if (tot[0]) tot = tot + {2'b00, in_mod};
        half = tot >> 1;
        if (half >= {2'b00, in_mod}) half = half - {2'b00, in_mod};
        exp_now = half[WIDTH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) d_vld[0] <= 1'b0;
        else     d_vld[0] <= in_valid;
        d_tag[0] <= in_tag;
        d_exp[0] <= exp_now;
        d_mod[0] <= in_mod;
        for (int k = 1; k < DEPTH; k++) begin
            if (rst) d_vld[k] <= 1'b0;
            else     d_vld[k] <= d_vld[k-1];
            d_tag[k] <= d_tag[k-1];
            d_exp[k] <= d_exp[k-1];
            d_mod[k] <= d_mod[k-1];
        end
    end

    // R1 R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == d_vld[DEPTH-1]);

    // R6
    tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_tag == d_tag[DEPTH-1]);

    // R2 R3 R4
    result_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sum == d_exp[DEPTH-1]);

    // R5
    below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sum < d_mod[DEPTH-1]);

endmodule

bind modhalf_unit modhalf_chk #(
    .WIDTH (WIDTH),
    .SEGS  (SEGS),
    .TAGW  (TAGW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_mod    (in_mod),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_sum   (out_sum)
);

// File: tb/modhalf_unit_tb.sv
`timescale 1ns/1ps
module modhalf_unit_tb;
    import modhalf_pkg::*;

    localparam int WIDTH = 32;
    localparam int SEGS  = 4;
    localparam int TAGW  = 4;
    localparam int LAT   = pipe_depth(SEGS);

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [TAGW-1:0]  in_tag;
    logic [WIDTH-1:0] in_a, in_b, in_mod;
    logic             out_valid;
    logic [TAGW-1:0]  out_tag;
    logic [WIDTH-1:0] out_sum;

    always #5 clk = ~clk;

    modhalf_unit #(.WIDTH(WIDTH), .SEGS(SEGS), .TAGW(TAGW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_a(in_a), .in_b(in_b), .in_mod(in_mod),
        .out_valid(out_valid), .out_tag(out_tag), .out_sum(out_sum)
    );

    typedef struct {
        logic [WIDTH-1:0] s;
        logic [TAGW-1:0]  tag;
        logic [WIDTH-1:0] n;
        int               due;
        string            rq;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic [TAGW-1:0] tag_ctr = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // Result as (A+B) times the inverse of two, modulo N, with the path tag.
    function automatic logic [WIDTH-1:0] model(input logic [WIDTH-1:0] a,
            input logic [WIDTH-1:0] b, input logic [WIDTH-1:0] n, output string rq);
        logic [WIDTH+1:0] r, h;
        r = ({2'b00, a} + {2'b00, b}) % {2'b00, n};
        h = r[0] ? (r + {2'b00, n}) >> 1 : r >> 1;
        if (({2'b00, a} + {2'b00, b}) % 2 == 0) rq = "R2";
        else if ((({2'b00, a} + {2'b00, b} + {2'b00, n}) >> 1) >= {2'b00, n}) rq = "R4";
        else rq = "R3";
        return h[WIDTH-1:0];
    endfunction

    task automatic issue(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [WIDTH-1:0] n, input string force_rq);
        exp_t e;
        string rq;
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a; in_b = b; in_mod = n; in_tag = tag_ctr;
        e.s   = model(a, b, n, rq);
        e.rq  = (force_rq != "") ? force_rq : rq;
        e.tag = tag_ctr;
        e.n   = n;
        e.due = cyc + LAT;
        q.push_back(e);
        tag_ctr = tag_ctr + 1'b1;
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic rand_op();
        logic [WIDTH-1:0] n;
        n = ($urandom >> ($urandom % WIDTH)) | 32'd1;
        issue($urandom % n, $urandom % n, n, "");
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected out_valid", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.due, "R1", "arrival cycle", 64'(cyc), 64'(e.due));
                check(out_sum == e.s, e.rq, "out_sum", 64'(out_sum), 64'(e.s));
                check(out_tag == e.tag, "R6", "out_tag", 64'(out_tag), 64'(e.tag));
                check(out_sum < e.n, "R5", "result below modulus", 64'(out_sum), 64'(e.n));
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_mod = 32'd1; in_tag = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(out_valid == 1'b0, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // R8: extremes of the modulus
        issue(32'd0, 32'd0, 32'd1, "R8");
        issue(32'hFFFF_FFFD, 32'hFFFF_FFFD, 32'hFFFF_FFFF, "R8");
        issue(32'hFFFF_FFFE, 32'hFFFF_FFFD, 32'hFFFF_FFFF, "R8");
        issue(32'hFFFF_FFFD, 32'd0, 32'hFFFF_FFFF, "R8");
        // R2, R3, R4 with a small modulus
        issue(32'd2, 32'd4, 32'd7, "");   // even: 3
        issue(32'd1, 32'd0, 32'd7, "");   // odd, fold: 4
        issue(32'd6, 32'd5, 32'd7, "");   // odd, fold then subtract: 2
        idle(LAT + 2);

        // Back-to-back random traffic (R1)
        for (int i = 0; i < 200; i++) rand_op();
        // Traffic with bubbles (R7)
        for (int i = 0; i < 200; i++) begin
            rand_op();
            if ($urandom % 3 == 0) idle(1 + $urandom % 4);
        end

        // R7: reset with operations in flight
        rand_op(); rand_op(); rand_op();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid after flush", 64'(out_valid), 64'd0);
        end

        for (int i = 0; i < 150; i++) rand_op();
        idle(LAT + 3);
        // R1: every accepted operation was delivered
        check(q.size() == 0, "R1", "results outstanding", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule